// File: doc/BRIEF.md
# Edge-Gated Duty Cycle Capture Timer

This block measures the low time and the period of an asynchronous digital input, one measurement after another, with no restart between them. A 16-bit counter advances on a prescaled tick. One edge type is the start/end edge: the counter value is latched into a capture register and the counter returns to zero. The opposite edge only latches the running count. With the falling edge chosen as the start/end edge, the rising-edge capture gives the low time and the next falling-edge capture gives the full period.

A single-shot gate keeps the counter at zero after enable until the first start/end edge arrives. Any opposite edges that come earlier are ignored. Each capture is tagged as an opposite-edge (low-time) or start-edge (period) value. Each capture raises an interrupt flag that stays set until it is cleared. If the counter wraps before the next start/end edge, a sticky overflow flag marks the measurement as invalid.

The captured value is the count just before the reload. A span of L input clocks at divider setting d therefore reads floor((L-1)/2^d). The input passes through a two-flop synchronizer, so each capture happens two clocks after the pin changes. Because every edge sees the same delay, measured spans are exact.

Top module: `duty_capture_timer`

## Requirements
- R1: After reset, cap_value is 0000h and cap_is_period, irq_flag and ovf_flag are 0.
- R2: On the opposite edge, the running count is captured without a reload and cap_is_period is 0. A span of L clocks after the start edge reads floor((L-1)/2^div_sel).
- R3: On the start/end edge during a measurement, the count is captured and reloaded to 0 in the same cycle, and cap_is_period is 1. A period of P clocks reads floor((P-1)/2^div_sel). Measurement continues cycle after cycle while run_en stays 1.
- R4: With pol_fall_start=1 the falling edge is the start/end edge. With pol_fall_start=0 the rising edge is the start/end edge.
- R5: The counter advances once every 2^div_sel clocks (div_sel=0 gives divide by 1), with the prescaler phase restarted on each start/end edge.
- R6: With oneshot_en=1, after enable the counter holds at 0 and opposite edges are ignored until the first start/end edge. That first start/end edge starts counting without making a capture or an interrupt.
- R7: With oneshot_en=0, the counter runs from one clock after enable, and every edge of either type captures immediately.
- R8: irq_flag is set on each capture while irq_en=1, stays set until irq_clr, and is never set by a capture while irq_en=0.
- R9: When the counter passes FFFFh it wraps to 0000h and sets ovf_flag, which stays set until irq_clr.
- R10: With run_en=0 the counter is held at 0 and edges on the pin cause no capture.
- R11: cap_value and cap_is_period change only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous measured signal |
| pol_fall_start | input | 1 | 1: falling edge starts/ends a cycle; 0: rising edge does |
| div_sel | input | 3 | Prescaler exponent, divide by 2^div_sel |
| run_en | input | 1 | Timer run enable |
| oneshot_en | input | 1 | Wait for the first start/end edge after enable |
| irq_en | input | 1 | Allow captures to set irq_flag |
| irq_clr | input | 1 | Clears irq_flag and ovf_flag |
| cap_value | output | 16 | Last captured count |
| cap_is_period | output | 1 | 1: last capture was a period; 0: a low (opposite-edge) time |
| irq_flag | output | 1 | Sticky capture interrupt flag |
| ovf_flag | output | 1 | Sticky counter wrap flag |

## Verification
The main measurement is driven with square waves of different low and high lengths, back to back. Two consecutive cycles of different lengths show that the reload happens on the start edge only and that no restart is needed. Swapping polarity and using a divide-by-four prescaler separate the start-edge choice from the tick rate. Each of the following patterns distinguishes a gated start from a free-running count: a lone opposite edge after single-shot arming, a free-run case whose first edge is an opposite edge, edges while disabled, and a low phase longer than 65536 clocks.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2
    } dct_mode_e;
endpackage

// File: rtl/dct_pin_sync.sv
module dct_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q, pre_max;

    always_comb begin
        pre_max = PRE_W'((32'd1 << div_sel) - 32'd1);
        if (restart || !en)       pre_d = '0;
        else if (pre_q >= pre_max) pre_d = '0;
        else                      pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = en && !restart && (pre_q >= pre_max);
endmodule

// File: rtl/duty_capture_timer.sv
module duty_capture_timer #(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 3,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             pol_fall_start,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             run_en,
    input  logic             oneshot_en,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_is_period,
    output logic             irq_flag,
    output logic             ovf_flag
);
    import dct_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        dct_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             per;
        logic             irq;
        logic             ovf;
    } dct_state_t;

    dct_state_t q, n_d;
    logic rise, fall, start_ev, other_ev;
    logic pre_en, pre_restart, tick, capture_evt;

    dct_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    assign start_ev    = pol_fall_start ? fall : rise;
    assign other_ev    = pol_fall_start ? rise : fall;
    assign pre_en      = run_en && (q.mode == ST_MEAS);
    assign pre_restart = start_ev || !pre_en;

    dct_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pre_en),
        .restart (pre_restart),
        .div_sel (div_sel),
        .tick    (tick)
    );

    always_comb begin
        n_d         = q;
        capture_evt = 1'b0;
        if (irq_clr) begin
            n_d.irq = 1'b0;
            n_d.ovf = 1'b0;
        end
        if (!run_en) begin
            n_d.mode = ST_IDLE;
            n_d.cnt  = '0;
        end else begin
            case (q.mode)
                ST_IDLE: begin
                    n_d.mode = oneshot_en ? ST_ARMED : ST_MEAS;
                    n_d.cnt  = '0;
                end
                ST_ARMED: begin
                    if (start_ev) n_d.mode = ST_MEAS;
                end
                ST_MEAS: begin
                    if (start_ev) begin
                        capture_evt = 1'b1;
                        n_d.cap     = q.cnt;
                        n_d.per     = 1'b1;
                        n_d.cnt     = '0;
                    end else begin
                        if (other_ev) begin
                            capture_evt = 1'b1;
                            n_d.cap     = q.cnt;
                            n_d.per     = 1'b0;
                        end
                        if (tick) begin
                            n_d.cnt = q.cnt + CNT_W'(1);
                            if (q.cnt == CNT_MAX) n_d.ovf = 1'b1;
                        end
                    end
                end
                default: n_d.mode = ST_IDLE;
            endcase
        end
        if (capture_evt && irq_en) n_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= ST_IDLE;
            q.cnt  <= '0;
            q.cap  <= '0;
            q.per  <= 1'b0;
            q.irq  <= 1'b0;
            q.ovf  <= 1'b0;
        end else begin
            q <= n_d;
        end
    end

    assign cap_value     = q.cap;
    assign cap_is_period = q.per;
    assign irq_flag      = q.irq;
    assign ovf_flag      = q.ovf;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             irq_en,
    input logic             irq_clr,
    input logic             capture_evt,
    input logic [1:0]       mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cap_value,
    input logic             irq_flag,
    input logic             ovf_flag
);
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq_flag) |=> !irq_flag);
    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(capture_evt));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !irq_clr) |=> ovf_flag);
    // R11
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_evt |=> $stable(cap_value));
    // R6
    armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == dct_pkg::ST_ARMED) |-> (!capture_evt && cnt_q == '0));
    // R10
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0));
endmodule

bind duty_capture_timer dct_checker #(.CNT_W(CNT_W)) u_dct_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .irq_en      (irq_en),
    .irq_clr     (irq_clr),
    .capture_evt (capture_evt),
    .mode_q      (q.mode),
    .cnt_q       (q.cnt),
    .cap_value   (cap_value),
    .irq_flag    (irq_flag),
    .ovf_flag    (ovf_flag)
);

// File: tb/duty_capture_timer_test.sv
module duty_capture_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b1;
    logic        pol_fall_start = 1'b1;
    logic [2:0]  div_sel = 3'd0;
    logic        run_en = 1'b0;
    logic        oneshot_en = 1'b1;
    logic        irq_en = 1'b1;
    logic        irq_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_is_period;
    logic        irq_flag;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    duty_capture_timer uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_in         (pin_in),
        .pol_fall_start (pol_fall_start),
        .div_sel        (div_sel),
        .run_en         (run_en),
        .oneshot_en     (oneshot_en),
        .irq_en         (irq_en),
        .irq_clr        (irq_clr),
        .cap_value      (cap_value),
        .cap_is_period  (cap_is_period),
        .irq_flag       (irq_flag),
        .ovf_flag       (ovf_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic setup(input logic pol, input logic [2:0] d, input logic os,
                         input logic idle);
        run_en = 1'b0;
        pol_fall_start = pol;
        div_sel = d;
        oneshot_en = os;
        pin_in = idle;
        clr_pulse();
        repeat (8) @(negedge clk);
        run_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // drive one level for n clocks, checking outputs 4 clocks after the edge
    task automatic seg(input logic lvl, input int n, input string tag,
                       input int exp_cap, input int exp_per, input int exp_irq);
        pin_in = lvl;
        repeat (4) @(negedge clk);
        check({tag, " cap_value"}, int'(cap_value), exp_cap);
        check({tag, " cap_is_period"}, int'(cap_is_period), exp_per);
        check({tag, " irq_flag"}, int'(irq_flag), exp_irq);
        clr_pulse();
        repeat (n - 5) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cap_value", int'(cap_value), 0);
        check("R1 cap_is_period", int'(cap_is_period), 0);
        check("R1 irq_flag", int'(irq_flag), 0);
        check("R1 ovf_flag", int'(ovf_flag), 0);
    endtask

    task automatic t_repeat_fall();
        setup(1'b1, 3'd0, 1'b1, 1'b1);
        seg(1'b0, 10, "R6 start edge no capture", 0, 0, 0);
        seg(1'b1, 15, "R2 low time", 9, 0, 1);
        seg(1'b0, 7, "R3 period", 24, 1, 1);
        seg(1'b1, 20, "R2 second low time", 6, 0, 1);
        seg(1'b0, 6, "R3 second period", 26, 1, 1);
    endtask

    task automatic t_oneshot();
        setup(1'b1, 3'd0, 1'b1, 1'b0);
        seg(1'b1, 10, "R6 early rise ignored", 26, 1, 0);
        seg(1'b0, 12, "R6 first fall starts", 26, 1, 0);
        seg(1'b1, 8, "R6 low after gate", 11, 0, 1);
        seg(1'b0, 6, "R6 period after gate", 19, 1, 1);
    endtask

    task automatic t_rise_start();
        setup(1'b0, 3'd0, 1'b1, 1'b0);
        seg(1'b1, 12, "R4 rise starts", 19, 1, 0);
        seg(1'b0, 9, "R4 fall is opposite edge", 11, 0, 1);
        seg(1'b1, 6, "R4 rise period", 20, 1, 1);
    endtask

    task automatic t_divider();
        setup(1'b1, 3'd2, 1'b1, 1'b1);
        seg(1'b0, 21, "R5 start div4", 20, 1, 0);
        seg(1'b1, 30, "R5 low div4", 5, 0, 1);
        seg(1'b0, 6, "R5 period div4", 12, 1, 1);
    endtask

    task automatic t_freerun();
        setup(1'b1, 3'd0, 1'b0, 1'b0);
        seg(1'b1, 10, "R7 free-run first rise", 5, 0, 1);
        seg(1'b0, 6, "R7 free-run fall", 15, 1, 1);
    endtask

    task automatic t_irq();
        setup(1'b1, 3'd0, 1'b1, 1'b1);
        irq_en = 1'b0;
        seg(1'b0, 10, "R8 start", 15, 1, 0);
        seg(1'b1, 8, "R8 masked capture", 9, 0, 0);
        irq_en = 1'b1;
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 enabled capture value", int'(cap_value), 17);
        check("R8 irq set", int'(irq_flag), 1);
        repeat (10) @(negedge clk);
        check("R8 irq held", int'(irq_flag), 1);
        clr_pulse();
        check("R8 irq cleared", int'(irq_flag), 0);
    endtask

    task automatic t_halt();
        setup(1'b1, 3'd0, 1'b1, 1'b1);
        seg(1'b0, 10, "R10 start", 17, 1, 0);
        run_en = 1'b0;
        seg(1'b1, 8, "R10 rise while halted", 17, 1, 0);
        seg(1'b0, 8, "R11 fall while halted", 17, 1, 0);
    endtask

    task automatic t_overflow();
        setup(1'b1, 3'd0, 1'b1, 1'b1);
        check("R9 ovf clear before", int'(ovf_flag), 0);
        pin_in = 1'b0;
        repeat (65540) @(negedge clk);
        check("R9 ovf after wrap", int'(ovf_flag), 1);
        repeat (70000 - 65540) @(negedge clk);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 wrapped low time", int'(cap_value), 4463);
        check("R9 ovf sticky", int'(ovf_flag), 1);
        clr_pulse();
        check("R9 ovf cleared", int'(ovf_flag), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_repeat_fall();
        t_oneshot();
        t_rise_start();
        t_divider();
        t_freerun();
        t_irq();
        t_halt();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule